// File: doc/BRIEF.md
# Third-Order Bitstream Decimator

This block turns the single-bit output of an isolated sigma-delta modulator into 16-bit unsigned samples. The modulator delivers its own clock with the data. The block oversamples both lines in a faster system clock domain. On each rising edge of the modulator clock it takes one data bit into a chain of three integrators. Once every 256 modulator edges a three-stage differentiator chain forms a sinc-cubed decimated result.

The raw result spans 0 to 2^24. It is scaled to a 16-bit offset-binary word with mid-scale at 32768. The one result that would not fit, a stream of nothing but ones, is clamped to the largest code. Each new word comes with a single-cycle strobe. The first words after reset cover a filter window that is only partly filled, so they are withheld.

The modulator clock must be markedly slower than the system clock, with each phase lasting at least four system clocks. The data line must be stable around each rising edge of the modulator clock.

Top module: `sdm_sinc3_decim`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `sample_vld` is 0 and `sample_out` is 0.
- R2: A data bit is taken only at a rising edge of `mod_clk`. Toggling `mod_dat` while `mod_clk` stays high, from two system clocks after the rising edge onward, does not change any output word.
- R3: Exactly one word is produced for every 256 rising edges of `mod_clk`. `sample_vld` is high for exactly one system clock per word.
- R4: The first three words after reset are suppressed. The first `sample_vld` pulse follows the 1024th rising edge of `mod_clk` after reset and comes before the 1025th.
- R5: For a bit pattern whose period divides 256, the settled code equals the density of ones times 65536: 50% gives 32768, 13/16 (81.25%) gives 53248 and 3/16 (18.75%) gives 12288. The internal decimated result never exceeds 2^24.
- R6: A stream of all zeros gives code 0.
- R7: A stream of all ones gives code 65535; the result 2^24 is clamped and does not wrap.
- R8: `sample_out` keeps its value in every cycle where `sample_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be several times faster than `mod_clk` |
| rst | input | 1 | Synchronous reset, active high |
| mod_clk | input | 1 | Clock that arrives with the bitstream, asynchronous to `clk` |
| mod_dat | input | 1 | Modulator bitstream, valid at the rising edge of `mod_clk` |
| sample_out | output | 16 | Decimated sample in offset binary; 32768 is zero input |
| sample_vld | output | 1 | Single-cycle strobe marking a new `sample_out` |

## Verification
The filter is driven with six streams:
- All zeros and all ones pin down the two ends of the scale. The all-ones stream shows whether the 2^24 result is clamped or wraps to zero.
- Alternating bits, a 13-of-16 pattern and a 3-of-16 pattern give three interior codes. Together they separate a correct scale and slice position from an off-by-one shift or a wrong sign.
- A repeat of the 13-of-16 pattern with extra data toggles during the high phase of the modulator clock shows whether the bit is captured at the edge rather than later.

Every stream starts from reset. This lets the count of modulator edges before the first strobe confirm the settling suppression, and the counts between later strobes confirm the ratio of 256.

// File: rtl/sdm_sinc3_pkg.sv
`timescale 1ns/1ps
package sdm_sinc3_pkg;

  // Number of integrator and differentiator stages (sinc cubed).
  localparam int unsigned CIC_ORDER = 3;

  // Bits needed to hold ratio^order for a single-bit unsigned input.
  function automatic int unsigned acc_width(input int unsigned order,
                                            input int unsigned dec_log2);
    return 1 + order * dec_log2;
  endfunction

endpackage

// File: rtl/sdm_sinc3_sync.sv
`timescale 1ns/1ps
// Brings modulator clock and data into the system domain and emits one
// step pulse per rising edge, with the data bit aligned to that pulse.
module sdm_sinc3_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mod_clk,
  input  logic mod_dat,
  output logic step,
  output logic bit_o
);

  logic [SYNC_STAGES-1:0] clk_sr, dat_sr;
  logic [SYNC_STAGES-1:0] clk_sr_nxt, dat_sr_nxt;
  logic                   clk_prev;

  if (SYNC_STAGES == 1) begin : g_single
    assign clk_sr_nxt = mod_clk;
    assign dat_sr_nxt = mod_dat;
  end else begin : g_chain
    assign clk_sr_nxt = {clk_sr[SYNC_STAGES-2:0], mod_clk};
    assign dat_sr_nxt = {dat_sr[SYNC_STAGES-2:0], mod_dat};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sr   <= '0;
      dat_sr   <= '0;
      clk_prev <= 1'b0;
      step     <= 1'b0;
      bit_o    <= 1'b0;
    end else begin
      clk_sr   <= clk_sr_nxt;
      dat_sr   <= dat_sr_nxt;
      clk_prev <= clk_sr[SYNC_STAGES-1];
      step     <= clk_sr[SYNC_STAGES-1] & ~clk_prev;
      bit_o    <= dat_sr[SYNC_STAGES-1];
    end
  end

endmodule

// File: rtl/sdm_sinc3_integ.sv
`timescale 1ns/1ps
// Cascade of wrap-around accumulators, advanced once per modulator step.
module sdm_sinc3_integ #(
  parameter int unsigned ORDER = 3,
  parameter int unsigned ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             bit_in,
  output logic [ACC_W-1:0] acc_out
);

  logic [ACC_W-1:0] tap [ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] addend;

    if (k == 0) begin : g_head
      assign addend = {{(ACC_W-1){1'b0}}, bit_in};
    end else begin : g_tail
      assign addend = tap[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst)       acc_q <= '0;
      else if (step) acc_q <= acc_q + addend;
    end

    assign tap[k] = acc_q;
  end

  assign acc_out = tap[ORDER-1];

endmodule

// File: rtl/sdm_sinc3_comb.sv
`timescale 1ns/1ps
// Decimation phase counter and differentiator chain evaluated in the
// system cycle of every 2**DEC_LOG2-th step.
module sdm_sinc3_comb #(
  parameter int unsigned ORDER    = 3,
  parameter int unsigned ACC_W    = 25,
  parameter int unsigned DEC_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [ACC_W-1:0] acc_in,
  output logic [ACC_W-1:0] comb_res,
  output logic             comb_vld
);

  logic [DEC_LOG2-1:0] phase_q;
  logic                tick;
  logic [ACC_W-1:0]    diff [ORDER+1];

  assign tick    = step && (phase_q == '1);
  assign diff[0] = acc_in;

  for (genvar k = 0; k < ORDER; k++) begin : g_diff
    logic [ACC_W-1:0] dly_q;

    assign diff[k+1] = diff[k] - dly_q;

    always_ff @(posedge clk) begin
      if (rst)       dly_q <= '0;
      else if (tick) dly_q <= diff[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      comb_res <= '0;
      comb_vld <= 1'b0;
    end else begin
      comb_vld <= tick;
      if (step) phase_q  <= phase_q + DEC_LOG2'(1);
      if (tick) comb_res <= diff[ORDER];
    end
  end

endmodule

// File: rtl/sdm_sinc3_out.sv
`timescale 1ns/1ps
// Scales the decimated result to offset binary, clamps full scale and
// withholds the settling words.
module sdm_sinc3_out #(
  parameter int unsigned ACC_W        = 25,
  parameter int unsigned OUT_W        = 16,
  parameter int unsigned SETTLE_WORDS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] comb_res,
  input  logic             comb_vld,
  output logic [OUT_W-1:0] sample_out,
  output logic             sample_vld
);

  localparam int unsigned SW = (SETTLE_WORDS > 0) ? $clog2(SETTLE_WORDS + 1) : 1;

  logic [SW-1:0]    settle_q;
  logic             settled;
  logic             full_scale;
  logic [OUT_W-1:0] scaled;
  logic [OUT_W-1:0] code;

  assign settled    = (settle_q == SW'(SETTLE_WORDS));
  assign full_scale = comb_res[ACC_W-1];

  if (ACC_W - 1 > OUT_W) begin : g_trunc
    logic unused_lsbs;
    assign scaled      = comb_res[ACC_W-2 -: OUT_W];
    assign unused_lsbs = ^comb_res[ACC_W-2-OUT_W:0];
  end else if (ACC_W - 1 == OUT_W) begin : g_exact
    assign scaled = comb_res[ACC_W-2:0];
  end else begin : g_pad
    assign scaled = {comb_res[ACC_W-2:0], {(OUT_W-ACC_W+1){1'b0}}};
  end

  assign code = full_scale ? '1 : scaled;

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_q   <= '0;
      sample_out <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= 1'b0;
      if (comb_vld) begin
        if (settled) begin
          sample_out <= code;
          sample_vld <= 1'b1;
        end else begin
          settle_q <= settle_q + SW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sdm_sinc3_decim.sv
`timescale 1ns/1ps
module sdm_sinc3_decim
  import sdm_sinc3_pkg::*;
#(
  parameter int unsigned DEC_LOG2     = 8,
  parameter int unsigned OUT_W        = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned SETTLE_WORDS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_clk,
  input  logic             mod_dat,
  output logic [OUT_W-1:0] sample_out,
  output logic             sample_vld
);

  localparam int unsigned ACC_W = acc_width(CIC_ORDER, DEC_LOG2);

  logic             step;
  logic             bit_s;
  logic [ACC_W-1:0] integ_out;
  logic [ACC_W-1:0] comb_res;
  logic             comb_vld;

  sdm_sinc3_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) sync_i (
    .clk    (clk),
    .rst    (rst),
    .mod_clk(mod_clk),
    .mod_dat(mod_dat),
    .step   (step),
    .bit_o  (bit_s)
  );

  sdm_sinc3_integ #(
    .ORDER(CIC_ORDER),
    .ACC_W(ACC_W)
  ) integ_i (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .bit_in (bit_s),
    .acc_out(integ_out)
  );

  sdm_sinc3_comb #(
    .ORDER   (CIC_ORDER),
    .ACC_W   (ACC_W),
    .DEC_LOG2(DEC_LOG2)
  ) comb_i (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .acc_in  (integ_out),
    .comb_res(comb_res),
    .comb_vld(comb_vld)
  );

  sdm_sinc3_out #(
    .ACC_W       (ACC_W),
    .OUT_W       (OUT_W),
    .SETTLE_WORDS(SETTLE_WORDS)
  ) out_i (
    .clk       (clk),
    .rst       (rst),
    .comb_res  (comb_res),
    .comb_vld  (comb_vld),
    .sample_out(sample_out),
    .sample_vld(sample_vld)
  );

endmodule

// File: rtl/sdm_sinc3_decim_chk.sv
`timescale 1ns/1ps
module sdm_sinc3_decim_chk #(
  parameter int unsigned DEC_LOG2     = 8,
  parameter int unsigned OUT_W        = 16,
  parameter int unsigned SETTLE_WORDS = 3,
  parameter int unsigned ACC_W        = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic [ACC_W-1:0] comb_res,
  input logic             comb_vld,
  input logic [OUT_W-1:0] sample_out,
  input logic             sample_vld
);

  localparam int unsigned RATIO = 2 ** DEC_LOG2;
  localparam int unsigned FIRST = (SETTLE_WORDS + 1) * RATIO;
  localparam int unsigned CW    = $clog2(FIRST + 2);
  localparam logic [ACC_W-1:0] FULL = {1'b1, {(ACC_W-1){1'b0}}};

  logic [CW-1:0] since_q;
  logic          seen_q;

  // Steps counted since reset or since the previous strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (sample_vld) begin
      since_q <= step ? CW'(1) : '0;
      seen_q  <= 1'b1;
    end else if (step && since_q != '1) begin
      since_q <= since_q + CW'(1);
    end
  end

  assert_word_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    sample_vld && seen_q |-> since_q == CW'(RATIO));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    sample_vld |=> !sample_vld);

  assert_settle_R4: assert property (@(posedge clk) disable iff (rst)
    sample_vld && !seen_q |-> since_q == CW'(FIRST));

  assert_comb_bound_R5: assert property (@(posedge clk) disable iff (rst)
    comb_vld |-> comb_res <= FULL);

  assert_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    comb_vld && comb_res == FULL |=> !sample_vld || sample_out == '1);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |-> $stable(sample_out));

endmodule

bind sdm_sinc3_decim sdm_sinc3_decim_chk #(
  .DEC_LOG2    (DEC_LOG2),
  .OUT_W       (OUT_W),
  .SETTLE_WORDS(SETTLE_WORDS),
  .ACC_W       (ACC_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .step      (step),
  .comb_res  (comb_res),
  .comb_vld  (comb_vld),
  .sample_out(sample_out),
  .sample_vld(sample_vld)
);

// File: tb/sdm_sinc3_decim_tb_top.sv
`timescale 1ns/1ps
module sdm_sinc3_decim_tb_top;

  localparam int RATIO = 256;
  localparam int FIRST = 4 * RATIO;

  logic        clk;
  logic        rst;
  logic        mod_clk;
  logic        mod_dat;
  logic [15:0] sample_out;
  logic        sample_vld;

  int  n_chk;
  int  n_fail;
  int  edges;
  int  idx;
  int  pat_sel;
  bit  glitch;
  bit  mod_run;

  sdm_sinc3_decim dut_i (
    .clk       (clk),
    .rst       (rst),
    .mod_clk   (mod_clk),
    .mod_dat   (mod_dat),
    .sample_out(sample_out),
    .sample_vld(sample_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic pat_bit(input int sel, input int i);
    case (sel)
      0:       return 1'b0;
      1:       return 1'b1;
      2:       return logic'(i % 2);
      3:       return (i % 16) < 13;
      default: return (i % 16) < 3;
    endcase
  endfunction

  // Modulator model: 11 system clocks per bit, data set while clock is low.
  initial begin
    int ph;
    ph      = 0;
    mod_clk = 1'b0;
    mod_dat = 1'b0;
    forever begin
      @(negedge clk);
      if (!mod_run) begin
        ph      = 0;
        mod_clk = 1'b0;
      end else begin
        case (ph)
          0: begin mod_clk = 1'b0; mod_dat = pat_bit(pat_sel, idx); end
          5: begin mod_clk = 1'b1; edges++; end
          8: if (glitch) mod_dat = ~mod_dat;
          10: begin if (glitch) mod_dat = ~mod_dat; idx++; end
          default: ;
        endcase
        ph = (ph == 10) ? 0 : ph + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_vld();
    do @(negedge clk); while (!sample_vld);
  endtask

  task automatic run_case(input int sel, input bit glt, input int exp_code,
                          input string tag);
    mod_run = 1'b0;
    rst     = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 strobe in reset", int'(sample_vld), 0);
    chk("R1 word in reset", int'(sample_out), 0);
    pat_sel = sel;
    glitch  = glt;
    idx     = 0;
    edges   = 0;
    @(negedge clk);
    rst     = 1'b0;
    mod_run = 1'b1;
    wait_vld();
    chk("R4 edges before first word", edges, FIRST);
    chk(tag, int'(sample_out), exp_code);
    @(negedge clk);
    chk("R3 strobe lasts one cycle", int'(sample_vld), 0);
    chk("R8 word held after strobe", int'(sample_out), exp_code);
    for (int w = 1; w <= 2; w++) begin
      wait_vld();
      chk("R3 edges per word", edges, FIRST + RATIO * w);
      chk(tag, int'(sample_out), exp_code);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog: actual %0d cycles expected completion", 200000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk   = 0;
    n_fail  = 0;
    rst     = 1'b1;
    mod_run = 1'b0;
    pat_sel = 0;
    glitch  = 1'b0;
    idx     = 0;
    edges   = 0;
    repeat (3) @(posedge clk);
    run_case(2, 1'b0, 32768, "R5 half density");
    run_case(1, 1'b0, 65535, "R7 all ones clamp");
    run_case(0, 1'b0, 0,     "R6 all zeros");
    run_case(3, 1'b0, 53248, "R5 13/16 density");
    run_case(4, 1'b0, 12288, "R5 3/16 density");
    run_case(3, 1'b1, 53248, "R2 toggles while clock high");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule